// File: doc/BRIEF.md
# MAC Control Frame Receive Filter

This block makes the final keep-or-discard call for a received Ethernet frame whose header has already been parsed. Address matching has been done upstream: the block receives a station-address hit, a hit on the control multicast address 01-80-C2-00-00-01, and the combined verdict of the standard filters (secondary addresses, hash and promiscuous modes). It also receives the frame's type field, its opcode and an integrity flag. From these inputs it recognises MAC control frames and PAUSE frames, applies the discard and pass rules for control frames, and signals the flow-control pause action.

Each frame is offered as a single-cycle strobe `fr_vld` together with its descriptor. There is no `ready`. The block can take a new frame on every cycle, including back to back, so it never applies back-pressure. The result comes out as a one-cycle `dec_vld` pulse, one clock after the strobe, carrying `dec_pass` and `pause_evt`. The consumer must accept it in that cycle. The flow-control type value is held in an internal register. It resets to 0x8808 and is loaded through a plain write strobe.

Top module: `ctlfilt_top`

## Requirements
- R1: After reset, `dec_vld`, `dec_pass` and `pause_evt` are 0, and the flow-control type register holds 0x8808.
- R2: For every cycle with `fr_vld`=1, `dec_vld` is 1 in exactly the next cycle and in no other. `dec_pass` and `pause_evt` are 0 whenever `dec_vld` is 0.
- R3: A frame with `fr_ok`=0 gives `dec_pass`=0 and `pause_evt`=0, whatever the control bits are.
- R4: With `cfg_rfce`=0, a good frame passes if and only if `hit_station` or `std_pass` is set, and `pause_evt` stays 0.
- R5: A frame is a control frame when (`hit_station` or `hit_ctl_mcast`) is set and `type_field` equals the flow-control type register. A frame whose type differs is filtered as an ordinary frame.
- R6: With `cfg_rfce`=1 and `cfg_dpf`=1, a good PAUSE frame (control frame with opcode 0x0001) that hits the station address is dropped.
- R7: `cfg_dpf` has no effect on a PAUSE frame that hits only the control multicast address. That frame passes if and only if `std_pass` is set.
- R8: With `cfg_rfce`=1, every good PAUSE frame gives `pause_evt`=1, whatever `cfg_dpf` is.
- R9: With `cfg_rfce`=1 and `cfg_pmcf`=1, a good control frame whose opcode is not 0x0001 passes.
- R10: With `cfg_rfce`=1 and `cfg_pmcf`=0, a good non-PAUSE control frame passes if and only if `hit_station` or `std_pass` is set.
- R11: A write with `cfg_type_we`=1 loads `cfg_type_wdata` into the type register. The new value applies to every frame strobed in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_vld | input | 1 | Frame descriptor strobe, one cycle per frame |
| fr_ok | input | 1 | Frame integrity good (CRC and length) |
| hit_station | input | 1 | Destination matches station address |
| hit_ctl_mcast | input | 1 | Destination matches control multicast address |
| std_pass | input | 1 | Standard filter accepts (secondary, hash, promiscuous) |
| type_field | input | 16 | Frame type/length field |
| opcode | input | 16 | MAC control opcode |
| cfg_rfce | input | 1 | Receive flow control enable |
| cfg_dpf | input | 1 | Discard PAUSE frames sent to station address |
| cfg_pmcf | input | 1 | Pass non-PAUSE MAC control frames |
| cfg_type_we | input | 1 | Type register write strobe |
| cfg_type_wdata | input | 16 | Type register write value |
| dec_vld | output | 1 | Decision valid, one cycle |
| dec_pass | output | 1 | Forward the frame to the host |
| pause_evt | output | 1 | A valid PAUSE frame was seen, so apply the pause action |

## Verification
The block holds only two pieces of state: the type register and the decision stage.

A wrong value in the type register changes which frames count as control frames. It therefore shows up on the first frame afterwards whose type sits on the boundary of recognition, such as a PAUSE frame with `cfg_dpf` set or a non-PAUSE frame with `cfg_pmcf` set. The bench probes both the reset value and a written value in this way.

A fault in the decision stage, such as a stuck or late `dec_vld`, appears at the ports on the very next cycle after a strobe. The scoreboard catches it as an unexpected or missing decision, including during back-to-back frames.

// File: rtl/ctlfilt_pkg.sv
package ctlfilt_pkg;
  localparam int unsigned TYPE_W = 16;
  localparam int unsigned OP_W   = 16;

  typedef struct packed {
    logic ctl;    // control frame recognised
    logic pause;  // control frame with the PAUSE opcode
  } frm_cls_t;
endpackage

// File: rtl/ctlfilt_type_reg.sv
module ctlfilt_type_reg #(
  parameter int unsigned             W       = 16,
  parameter logic [W-1:0]            RST_VAL = 16'h8808
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)  value <= RST_VAL;
    else if (we) value <= wdata;
  end

  AST_TYPE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> value == $past(wdata)); // R11
endmodule

// File: rtl/ctlfilt_classify.sv
module ctlfilt_classify
  import ctlfilt_pkg::*;
#(
  parameter int unsigned     TW       = TYPE_W,
  parameter int unsigned     OW       = OP_W,
  parameter logic [OW-1:0]   PAUSE_OP = 16'h0001
) (
  input  logic          hit_station,
  input  logic          hit_ctl_mcast,
  input  logic [TW-1:0] type_field,
  input  logic [TW-1:0] fc_type,
  input  logic [OW-1:0] opcode,
  output frm_cls_t      cls
);
  logic dest_ok;
  assign dest_ok = hit_station | hit_ctl_mcast;

  always_comb begin
    cls.ctl   = dest_ok && (type_field == fc_type);
    cls.pause = cls.ctl && (opcode == PAUSE_OP);
  end
endmodule

// File: rtl/ctlfilt_decide.sv
module ctlfilt_decide
  import ctlfilt_pkg::*;
(
  input  frm_cls_t cls,
  input  logic     fr_ok,
  input  logic     hit_station,
  input  logic     std_pass,
  input  logic     cfg_rfce,
  input  logic     cfg_dpf,
  input  logic     cfg_pmcf,
  output logic     pass,
  output logic     pause
);
  logic base;
  assign base = hit_station | std_pass;

  always_comb begin
    pass  = 1'b0;
    pause = 1'b0;
    if (fr_ok) begin
      if (!cfg_rfce) begin
        pass = base;
      end else if (cls.pause) begin
        pause = 1'b1;
        pass  = (hit_station && cfg_dpf) ? std_pass && !hit_station : base;
      end else if (cls.ctl) begin
        pass = base | cfg_pmcf;
      end else begin
        pass = base;
      end
    end
  end
endmodule

// File: rtl/ctlfilt_top.sv
module ctlfilt_top
  import ctlfilt_pkg::*;
#(
  parameter logic [TYPE_W-1:0] FC_TYPE_RST = 16'h8808,
  parameter logic [OP_W-1:0]   PAUSE_OP    = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_vld,
  input  logic              fr_ok,
  input  logic              hit_station,
  input  logic              hit_ctl_mcast,
  input  logic              std_pass,
  input  logic [TYPE_W-1:0] type_field,
  input  logic [OP_W-1:0]   opcode,
  input  logic              cfg_rfce,
  input  logic              cfg_dpf,
  input  logic              cfg_pmcf,
  input  logic              cfg_type_we,
  input  logic [TYPE_W-1:0] cfg_type_wdata,
  output logic              dec_vld,
  output logic              dec_pass,
  output logic              pause_evt
);
  logic [TYPE_W-1:0] fc_type;
  frm_cls_t          cls;
  logic              pass_c, pause_c;

  ctlfilt_type_reg #(.W(TYPE_W), .RST_VAL(FC_TYPE_RST)) u_type (
    .clk(clk), .rst_n(rst_n), .we(cfg_type_we), .wdata(cfg_type_wdata), .value(fc_type)
  );

  ctlfilt_classify #(.TW(TYPE_W), .OW(OP_W), .PAUSE_OP(PAUSE_OP)) u_cls (
    .hit_station(hit_station), .hit_ctl_mcast(hit_ctl_mcast), .type_field(type_field),
    .fc_type(fc_type), .opcode(opcode), .cls(cls)
  );

  ctlfilt_decide u_dec (
    .cls(cls), .fr_ok(fr_ok), .hit_station(hit_station), .std_pass(std_pass),
    .cfg_rfce(cfg_rfce), .cfg_dpf(cfg_dpf), .cfg_pmcf(cfg_pmcf),
    .pass(pass_c), .pause(pause_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld   <= 1'b0;
      dec_pass  <= 1'b0;
      pause_evt <= 1'b0;
    end else begin
      dec_vld   <= fr_vld;
      dec_pass  <= fr_vld & pass_c;
      pause_evt <= fr_vld & pause_c;
    end
  end

  AST_DEC_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> dec_vld == $past(fr_vld)); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> !dec_pass && !pause_evt); // R2
  AST_BAD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    fr_vld && !fr_ok |=> !dec_pass && !pause_evt); // R3
  AST_NO_FC_NO_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_vld && !cfg_rfce |=> !pause_evt); // R4
  AST_DPF_STATION: assert property (@(posedge clk) disable iff (!rst_n)
    fr_vld && cfg_rfce && cfg_dpf && cls.pause && hit_station |=> !dec_pass); // R6
  AST_PAUSE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    fr_vld && fr_ok && cfg_rfce && cls.pause |=> pause_evt); // R8
  AST_PMCF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    fr_vld && fr_ok && cfg_rfce && cfg_pmcf && cls.ctl && !cls.pause |=> dec_pass); // R9
endmodule

// File: tb/test_ctlfilt_top.sv
module test_ctlfilt_top;
  logic clk = 1'b0;
  logic rst_n;
  logic fr_vld, fr_ok, hit_station, hit_ctl_mcast, std_pass;
  logic [15:0] type_field, opcode, cfg_type_wdata;
  logic cfg_rfce, cfg_dpf, cfg_pmcf, cfg_type_we;
  logic dec_vld, dec_pass, pause_evt;

  int checks = 0;
  int fails  = 0;
  logic [15:0] tb_fct = 16'h8808;

  typedef struct { logic pass; logic pause; string req; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  ctlfilt_top i_ctlfilt_top (
    .clk(clk), .rst_n(rst_n), .fr_vld(fr_vld), .fr_ok(fr_ok),
    .hit_station(hit_station), .hit_ctl_mcast(hit_ctl_mcast), .std_pass(std_pass),
    .type_field(type_field), .opcode(opcode), .cfg_rfce(cfg_rfce), .cfg_dpf(cfg_dpf),
    .cfg_pmcf(cfg_pmcf), .cfg_type_we(cfg_type_we), .cfg_type_wdata(cfg_type_wdata),
    .dec_vld(dec_vld), .dec_pass(dec_pass), .pause_evt(pause_evt)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic exp_t model(input logic ok, st, mc, sp, input logic [15:0] ty, op,
                                 input logic rf, dp, pm, input string req);
    exp_t e;
    logic ctl, pse, base;
    ctl  = (st || mc) && (ty == tb_fct);       // R5
    pse  = ctl && (op == 16'h0001);
    base = st || sp;
    e.req = req; e.pass = 1'b0; e.pause = 1'b0;
    if (ok) begin
      if (!rf)              e.pass = base;                 // R4
      else if (pse) begin
        e.pause = 1'b1;                                    // R8
        e.pass  = (st && dp) ? 1'b0 : base;                // R6 R7
      end
      else if (ctl)         e.pass = base || pm;           // R9 R10
      else                  e.pass = base;
    end
    return e;
  endfunction

  task automatic frame(input logic ok, st, mc, sp, input logic [15:0] ty, op,
                       input logic rf, dp, pm, input string req);
    @(negedge clk);
    fr_vld = 1'b1; fr_ok = ok; hit_station = st; hit_ctl_mcast = mc; std_pass = sp;
    type_field = ty; opcode = op; cfg_rfce = rf; cfg_dpf = dp; cfg_pmcf = pm;
    q.push_back(model(ok, st, mc, sp, ty, op, rf, dp, pm, req));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fr_vld = 1'b0; cfg_type_we = 1'b0;
    end
  endtask

  // Monitor: compare every decision with the queue head
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (dec_vld) begin
        if (q.size() == 0) chk(1'b1, 1'b0, "R2 unexpected dec_vld");
        else begin
          exp_t e;
          e = q.pop_front();
          chk(dec_pass,  e.pass,  {e.req, " pass"});
          chk(pause_evt, e.pause, {e.req, " pause"});
        end
      end else begin
        chk(dec_pass | pause_evt, 1'b0, "R2 outputs quiet when idle");
      end
    end
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fr_vld = 1'b0; fr_ok = 1'b0; hit_station = 1'b0; hit_ctl_mcast = 1'b0;
    std_pass = 1'b0; type_field = '0; opcode = '0; cfg_rfce = 1'b0; cfg_dpf = 1'b0;
    cfg_pmcf = 1'b0; cfg_type_we = 1'b0; cfg_type_wdata = '0;
    repeat (3) @(negedge clk);
    chk(dec_vld, 1'b0, "R1 dec_vld in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(dec_vld | dec_pass | pause_evt, 1'b0, "R1 outputs after reset");

    // R1 / R6: default type 0x8808 recognised, station PAUSE discarded
    frame(1, 1, 0, 0, 16'h8808, 16'h0001, 1, 1, 0, "R1 R6 default type station PAUSE dpf");
    frame(1, 1, 0, 0, 16'h8808, 16'h0001, 1, 0, 0, "R6 station PAUSE no dpf");
    idle(2);
    // R7: multicast PAUSE unaffected by dpf
    frame(1, 0, 1, 1, 16'h8808, 16'h0001, 1, 1, 0, "R7 mcast PAUSE std pass");
    frame(1, 0, 1, 0, 16'h8808, 16'h0001, 1, 1, 0, "R7 mcast PAUSE std reject");
    frame(1, 0, 1, 0, 16'h8808, 16'h0001, 1, 0, 1, "R8 mcast PAUSE no dpf");
    // R9 / R10: non-PAUSE control frames
    frame(1, 0, 1, 0, 16'h8808, 16'h0002, 1, 0, 1, "R9 ctl pmcf set");
    frame(1, 0, 1, 0, 16'h8808, 16'h0002, 1, 0, 0, "R10 ctl pmcf clear reject");
    frame(1, 0, 1, 1, 16'h8808, 16'h0003, 1, 0, 0, "R10 ctl pmcf clear std pass");
    frame(1, 1, 0, 0, 16'h8808, 16'h0000, 1, 0, 0, "R10 ctl station pmcf clear");
    idle(1);
    // R5: type mismatch treated as ordinary frame
    frame(1, 0, 1, 0, 16'h0800, 16'h0002, 1, 0, 1, "R5 type mismatch pmcf");
    frame(1, 1, 0, 0, 16'h0800, 16'h0001, 1, 1, 0, "R5 type mismatch station dpf");
    frame(1, 0, 0, 0, 16'h8808, 16'h0001, 1, 1, 1, "R5 no dest hit");
    // R4: flow control disabled
    frame(1, 1, 0, 0, 16'h8808, 16'h0001, 0, 1, 1, "R4 rfce off station PAUSE");
    frame(1, 0, 1, 0, 16'h8808, 16'h0002, 0, 0, 1, "R4 rfce off mcast ctl");
    frame(1, 0, 0, 1, 16'h0800, 16'h0000, 0, 0, 0, "R4 rfce off std pass");
    // R3: bad frames
    frame(0, 1, 0, 1, 16'h8808, 16'h0001, 1, 0, 1, "R3 bad PAUSE");
    frame(0, 1, 0, 1, 16'h0800, 16'h0000, 0, 0, 0, "R3 bad ordinary");
    idle(2);

    // R11: reprogram type register
    @(negedge clk);
    cfg_type_we = 1'b1; cfg_type_wdata = 16'h88aa;
    @(negedge clk);
    cfg_type_we = 1'b0; tb_fct = 16'h88aa;
    frame(1, 1, 0, 0, 16'h88aa, 16'h0001, 1, 1, 0, "R11 new type PAUSE dpf");
    frame(1, 1, 0, 0, 16'h8808, 16'h0001, 1, 1, 0, "R11 old type now ordinary");
    frame(1, 0, 1, 0, 16'h88aa, 16'h0005, 1, 0, 1, "R11 new type ctl pmcf");
    idle(3);

    chk(q.size() == 0, 1'b1, "R2 every strobe answered");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule